// File: doc/BRIEF.md
# Endpoint Control and Status Register Bank

This block holds one 16-bit control and status word for each endpoint of a full-speed USB device. Software reaches the words over a simple single-cycle read/write bus. Hardware reaches them through a one-cycle transaction-result report from the serial engine. Each word mixes four kinds of access:

- plain read/write configuration fields;
- a read-only reception-kind flag;
- toggle-on-one fields, where writing 1 inverts the bit and writing 0 keeps it;
- completion flags that software can only clear, by writing 0, while writing 1 keeps them.

Because every hardware-owned bit has a write value that leaves it alone, software can store a whole word without first reading it. A bit that hardware changes in the meantime is therefore never lost.

Each report passes through a per-endpoint event decoder. The decoder maps the report onto one of six named events, which form the enumerated state of the update logic:

- `EV_NONE`: nothing to change.
- `EV_RX_DATA`: OUT data accepted.
- `EV_RX_SETUP`: SETUP data accepted on an endpoint that is not a control endpoint.
- `EV_CTL_SETUP_OK`: SETUP accepted on a control endpoint.
- `EV_CTL_SETUP_BAD`: SETUP token seen on a control endpoint, but no data accepted.
- `EV_TX_DATA`: IN data delivered.

The transitions are the following. Every event other than `EV_NONE` moves the word to its updated value in the next cycle. A bus reset moves every word to its cleared-configuration value. A software write moves the addressed word as the field rules below state.

Each endpoint drives its own interrupt request line. The line is high while either of the endpoint's completion flags is set.

Top module: `ep_csr_bank`

## Requirements
- R1: After `rst_n` is released, every word reads 0x0000 and every bit of `irq` is 0.
- R2: A write or read addresses endpoint n through `cpu_addr` = n (byte offset 4·n, so only byte-address bits 4:2 are present). `cpu_rdata` shows the addressed word in the same cycle. A write changes only the addressed word, one cycle later.
- R3: The plain fields hold the written value: bits 10:9 (endpoint type: 00 bulk, 01 control, 10 isochronous, 11 interrupt), bit 8 (kind) and bits 3:0 (device address). Bit 11 (setup flag) ignores writes.
- R4: Writing 1 to bit 14, 13, 12, 6, 5 or 4 inverts that bit. Writing 0 leaves it unchanged.
- R5: Writing 0 to bit 15 (receive-done) or bit 7 (transmit-done) clears that bit. Writing 1 leaves it unchanged.
- R6: A report with `xact_dir` 00 (OUT) on an endpoint that is not isochronous sets bit 15, clears bit 11 and inverts bit 14, provided `xact_ack`=1, `xact_err`=0 and `xact_pid` equals bit 14 (0 = DATA0, 1 = DATA1).
- R7: An OUT report on an endpoint that is not isochronous changes nothing when the handshake was not ACK, when `xact_err`=1, or when the PID does not match bit 14.
- R8: A report with `xact_dir` 01 (SETUP) on a control endpoint (type 01) sets bits 15 and 11 and leaves bit 14 at 1, provided it carries ACK, no error and DATA0. Otherwise it clears only bit 14.
- R9: On an isochronous endpoint (type 10), a report without error applies as follows. OUT sets bit 15, clears bit 11 and inverts bit 14, whatever the ACK and PID values. IN (`xact_dir` 10) sets bit 7 and inverts bit 6. A report with an error changes nothing.
- R10: An IN report on an endpoint that is not isochronous sets bit 7 and inverts bit 6 when `xact_ack`=1 and `xact_err`=0. Otherwise it changes nothing.
- R11: While `usb_rst` is high, each word keeps bits 15 and 7 and clears every other bit. Writes and reports in that cycle are ignored.
- R12: When a report and a write hit the same word in the same cycle:
  - A hardware set of a done flag wins over a written 0.
  - A hardware toggle and a written toggle combine as exclusive-or.
- R13: `irq[n]` equals bit 15 OR bit 7 of word n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_rst | input | 1 | Bus or forced reset, one cycle per pulse |
| cpu_addr | input | 3 | Word index (byte-address bits 4:2) |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Addressed word, combinational |
| xact_valid | input | 1 | Transaction report strobe |
| xact_ep | input | 3 | Endpoint of the report |
| xact_dir | input | 2 | 00 OUT, 01 SETUP, 10 IN, 11 ignored |
| xact_pid | input | 1 | Data PID, 0 DATA0, 1 DATA1 |
| xact_ack | input | 1 | An ACK handshake closed the transaction |
| xact_err | input | 1 | Protocol or CRC error |
| irq | output | 8 | Per-endpoint interrupt request |

## Verification
The assertions assume that a transaction report is a single-cycle strobe that names one endpoint and carries a defined direction, PID, ACK and error value. They also assume that `usb_rst` is a synchronous pulse, seen by the same clock as the reports. The stimulus drives every input at the falling edge and holds it for exactly one rising edge. It raises the report strobe only with fully specified fields, and it drops back to idle before the next operation, so each checked word reflects exactly one update. Collisions between a report and a write, and a reset arriving together with traffic, are created on purpose in a single cycle to cover the priority rules.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

    localparam int WORD_W = 16;

    typedef struct packed {
        logic       rx_done;
        logic       rx_tog;
        logic [1:0] rx_stat;
        logic       setup;
        logic [1:0] ep_type;
        logic       ep_kind;
        logic       tx_done;
        logic       tx_tog;
        logic [1:0] tx_stat;
        logic [3:0] dev_addr;
    } ep_word_t;

    localparam logic [1:0] TYPE_CTRL = 2'b01;
    localparam logic [1:0] TYPE_ISO  = 2'b10;

    localparam logic [1:0] DIR_OUT   = 2'b00;
    localparam logic [1:0] DIR_SETUP = 2'b01;
    localparam logic [1:0] DIR_IN    = 2'b10;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RX_DATA,
        EV_RX_SETUP,
        EV_CTL_SETUP_OK,
        EV_CTL_SETUP_BAD,
        EV_TX_DATA
    } ep_event_e;

endpackage

// File: rtl/ep_event_decode.sv
module ep_event_decode
    import ep_bank_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] ep_type,
    input  logic       rx_tog,
    input  logic [1:0] dir,
    input  logic       pid,
    input  logic       ack,
    input  logic       err,
    output ep_event_e  ev
);

    logic is_iso;
    logic is_ctrl;
    logic rx_accept;
    logic tx_accept;

    assign is_iso  = (ep_type == TYPE_ISO);
    assign is_ctrl = (ep_type == TYPE_CTRL);

    // isochronous: no handshake, no toggle matching
    assign rx_accept = is_iso ? !err : (ack && !err && (pid == rx_tog));
    assign tx_accept = is_iso ? !err : (ack && !err);

    always_comb begin
        ev = EV_NONE;
        if (hit) begin
            unique case (dir)
                DIR_OUT: begin
                    if (rx_accept) ev = EV_RX_DATA;
                end
                DIR_SETUP: begin
                    if (is_ctrl)
                        ev = (ack && !err && !pid) ? EV_CTL_SETUP_OK : EV_CTL_SETUP_BAD;
                    else if (rx_accept)
                        ev = EV_RX_SETUP;
                end
                DIR_IN: begin
                    if (tx_accept) ev = EV_TX_DATA;
                end
                default: ev = EV_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ep_reg.sv
module ep_reg
    import ep_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_rst,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic              x_hit,
    input  logic [1:0]        x_dir,
    input  logic              x_pid,
    input  logic              x_ack,
    input  logic              x_err,
    output logic [WORD_W-1:0] word_q
);

    ep_word_t  reg_q;
    ep_word_t  reg_d;
    ep_word_t  hw_v;
    ep_word_t  wr_v;
    ep_event_e ev;
    logic      rx_set;
    logic      tx_set;
    logic      unused_ro_bit;

    assign wr_v          = ep_word_t'(wdata);
    assign unused_ro_bit = wr_v.setup;

    ep_event_decode u_dec (
        .hit     (x_hit),
        .ep_type (reg_q.ep_type),
        .rx_tog  (reg_q.rx_tog),
        .dir     (x_dir),
        .pid     (x_pid),
        .ack     (x_ack),
        .err     (x_err),
        .ev      (ev)
    );

    // hardware half of the update
    always_comb begin
        hw_v   = reg_q;
        rx_set = 1'b0;
        tx_set = 1'b0;
        unique case (ev)
            EV_NONE: ;
            EV_RX_DATA: begin
                rx_set       = 1'b1;
                hw_v.rx_tog  = ~reg_q.rx_tog;
                hw_v.setup   = 1'b0;
            end
            EV_RX_SETUP: begin
                rx_set       = 1'b1;
                hw_v.rx_tog  = ~reg_q.rx_tog;
                hw_v.setup   = 1'b1;
            end
            EV_CTL_SETUP_OK: begin
                rx_set       = 1'b1;
                hw_v.rx_tog  = 1'b1;
                hw_v.setup   = 1'b1;
            end
            EV_CTL_SETUP_BAD: begin
                hw_v.rx_tog  = 1'b0;
            end
            EV_TX_DATA: begin
                tx_set       = 1'b1;
                hw_v.tx_tog  = ~reg_q.tx_tog;
            end
            default: ;
        endcase
    end

    // software half, layered on top; hardware sets of done flags win
    always_comb begin
        reg_d = hw_v;
        if (wr_hit) begin
            reg_d.rx_tog   = hw_v.rx_tog  ^ wr_v.rx_tog;
            reg_d.rx_stat  = hw_v.rx_stat ^ wr_v.rx_stat;
            reg_d.tx_tog   = hw_v.tx_tog  ^ wr_v.tx_tog;
            reg_d.tx_stat  = hw_v.tx_stat ^ wr_v.tx_stat;
            reg_d.ep_type  = wr_v.ep_type;
            reg_d.ep_kind  = wr_v.ep_kind;
            reg_d.dev_addr = wr_v.dev_addr;
            reg_d.rx_done  = reg_q.rx_done & wr_v.rx_done;
            reg_d.tx_done  = reg_q.tx_done & wr_v.tx_done;
        end
        if (rx_set) reg_d.rx_done = 1'b1;
        if (tx_set) reg_d.tx_done = 1'b1;
        if (usb_rst) begin
            reg_d         = '0;
            reg_d.rx_done = reg_q.rx_done;
            reg_d.tx_done = reg_q.tx_done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign word_q = reg_q;

    p_rst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        usb_rst |=> ((word_q & 16'h7F7F) == 16'h0000));

    p_rst_keeps_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        usb_rst |=> (reg_q.rx_done == $past(reg_q.rx_done) &&
                     reg_q.tx_done == $past(reg_q.tx_done)));

    p_hw_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (x_hit && ev != EV_NONE && ev != EV_CTL_SETUP_BAD && ev != EV_TX_DATA && !usb_rst)
            |=> reg_q.rx_done);

    p_rx_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_q.rx_done) |-> $past(x_hit));

    p_setup_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_hit && !usb_rst) |=> $stable(reg_q.setup));

    p_tx_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_q.tx_done) |-> $past(x_hit && x_dir == DIR_IN));

endmodule

// File: rtl/ep_read_mux.sv
module ep_read_mux
    import ep_bank_pkg::*;
#(
    parameter int NUM_EP = 8,
    localparam int IDX_W = $clog2(NUM_EP)
) (
    input  logic [NUM_EP-1:0][WORD_W-1:0] words,
    input  logic [IDX_W-1:0]              sel,
    output logic [WORD_W-1:0]             rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (sel == IDX_W'(i)) rdata = words[i];
        end
    end

endmodule

// File: rtl/ep_csr_bank.sv
module ep_csr_bank
    import ep_bank_pkg::*;
#(
    parameter int NUM_EP = 8,
    localparam int IDX_W = $clog2(NUM_EP),
    localparam int ADDR_HI = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               usb_rst,
    input  logic [ADDR_HI:2]   cpu_addr,
    input  logic               cpu_we,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic [WORD_W-1:0]  cpu_rdata,
    input  logic               xact_valid,
    input  logic [IDX_W-1:0]   xact_ep,
    input  logic [1:0]         xact_dir,
    input  logic               xact_pid,
    input  logic               xact_ack,
    input  logic               xact_err,
    output logic [NUM_EP-1:0]  irq
);

    logic [NUM_EP-1:0][WORD_W-1:0] words;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic wr_hit;
        logic x_hit;

        assign wr_hit = cpu_we && (cpu_addr == IDX_W'(g));
        assign x_hit  = xact_valid && (xact_ep == IDX_W'(g));

        ep_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .usb_rst (usb_rst),
            .wr_hit  (wr_hit),
            .wdata   (cpu_wdata),
            .x_hit   (x_hit),
            .x_dir   (xact_dir),
            .x_pid   (xact_pid),
            .x_ack   (xact_ack),
            .x_err   (xact_err),
            .word_q  (words[g])
        );

        assign irq[g] = words[g][15] | words[g][7];
    end

    ep_read_mux #(.NUM_EP(NUM_EP)) u_mux (
        .words (words),
        .sel   (cpu_addr),
        .rdata (cpu_rdata)
    );

    p_irq_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_rst && irq == '0) |=> (irq == '0));

endmodule

// File: tb/ep_csr_bank_bench.sv
`timescale 1ns/1ps
module ep_csr_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usb_rst = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        xact_valid = 1'b0;
    logic [2:0]  xact_ep = '0;
    logic [1:0]  xact_dir = '0;
    logic        xact_pid = 1'b0;
    logic        xact_ack = 1'b0;
    logic        xact_err = 1'b0;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] mdl [8];
    int          q_ep  [$];
    logic [15:0] q_exp [$];
    string       q_tag [$];

    always #2 clk = ~clk;

    ep_csr_bank u_ep_csr_bank (
        .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .xact_valid(xact_valid), .xact_ep(xact_ep),
        .xact_dir(xact_dir), .xact_pid(xact_pid), .xact_ack(xact_ack),
        .xact_err(xact_err), .irq(irq)
    );

    // reference model built from the requirement text
    function automatic void m_step(bit w, int wep, logic [15:0] wd,
                                   bit x, int xep, logic [1:0] dir,
                                   bit pid, bit ack, bit err, bit rst);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] v;
            bit hrx, htx, iso, ctl;
            v = mdl[i];
            if (rst) begin
                mdl[i] = v & 16'h8080;
                continue;
            end
            hrx = 0; htx = 0;
            iso = (v[10:9] == 2'b10);
            ctl = (v[10:9] == 2'b01);
            if (x && xep == i) begin
                if (dir == 2'b00) begin
                    if (iso ? !err : (ack && !err && pid == v[14])) begin
                        hrx = 1; v[14] = ~v[14]; v[11] = 0;
                    end
                end else if (dir == 2'b01) begin
                    if (ctl) begin
                        if (ack && !err && !pid) begin
                            hrx = 1; v[14] = 1; v[11] = 1;
                        end else v[14] = 0;
                    end else if (iso ? !err : (ack && !err && pid == v[14])) begin
                        hrx = 1; v[14] = ~v[14]; v[11] = 1;
                    end
                end else if (dir == 2'b10) begin
                    if (iso ? !err : (ack && !err)) begin
                        htx = 1; v[6] = ~v[6];
                    end
                end
            end
            if (w && wep == i) begin
                v[14]    = v[14] ^ wd[14];
                v[13:12] = v[13:12] ^ wd[13:12];
                v[6]     = v[6] ^ wd[6];
                v[5:4]   = v[5:4] ^ wd[5:4];
                v[10:8]  = wd[10:8];
                v[3:0]   = wd[3:0];
                if (!wd[15]) v[15] = 0;
                if (!wd[7])  v[7]  = 0;
            end
            if (hrx) v[15] = 1;
            if (htx) v[7]  = 1;
            mdl[i] = v;
        end
    endfunction

    task automatic expect_ep(int ep, string tag);
        q_ep.push_back(ep);
        q_exp.push_back(mdl[ep]);
        q_tag.push_back(tag);
    endtask

    task automatic drain();
        wait (q_ep.size() == 0);
    endtask

    // driver: one cycle of activity, then expectations queued
    task automatic op(bit w, int wep, logic [15:0] wd,
                      bit x, int xep, logic [1:0] dir, bit pid, bit ack, bit err,
                      bit rst, string tag);
        @(negedge clk);
        cpu_we     = w;
        cpu_addr   = 3'(wep);
        cpu_wdata  = wd;
        xact_valid = x;
        xact_ep    = 3'(xep);
        xact_dir   = dir;
        xact_pid   = pid;
        xact_ack   = ack;
        xact_err   = err;
        usb_rst    = rst;
        @(posedge clk);
        #1;
        cpu_we = 0; xact_valid = 0; usb_rst = 0;
        m_step(w, wep, wd, x, xep, dir, pid, ack, err, rst);
        if (w) expect_ep(wep, tag);
        if (x && !(w && wep == xep)) expect_ep(xep, tag);
        if (rst) for (int i = 0; i < 8; i++) expect_ep(i, tag);
        drain();
    endtask

    task automatic wr(int ep, logic [15:0] wd, string tag);
        op(1, ep, wd, 0, 0, 2'b00, 0, 0, 0, 0, tag);
    endtask

    task automatic rep(int ep, logic [1:0] dir, bit pid, bit ack, bit err, string tag);
        op(0, 0, 16'h0000, 1, ep, dir, pid, ack, err, 0, tag);
    endtask

    // monitor: reads back each expected word and its interrupt line
    initial begin
        forever begin
            int ep; logic [15:0] ex; string tg;
            wait (q_ep.size() > 0);
            @(negedge clk);
            #1;
            ep = q_ep[0]; ex = q_exp[0]; tg = q_tag[0];
            cpu_addr = 3'(ep);
            #1;
            checks++;
            if (cpu_rdata !== ex) begin
                errors++;
                $display("FAIL %s ep%0d word: actual=%h expected=%h", tg, ep, cpu_rdata, ex);
            end
            checks++;
            if (irq[ep] !== (ex[15] | ex[7])) begin
                errors++;
                $display("FAIL R13 (%s) ep%0d irq: actual=%b expected=%b",
                         tg, ep, irq[ep], ex[15] | ex[7]);
            end
            void'(q_ep.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
        end
    end

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 8; i++) expect_ep(i, "R1");
        drain();
        checks++;
        if (irq !== 8'h00) begin
            errors++;
            $display("FAIL R1 irq: actual=%h expected=00", irq);
        end

        // R2, R3: plain fields, read-only setup bit, addressing
        wr(2, 16'h0F8D, "R3");
        wr(3, 16'h0B85, "R2");
        expect_ep(2, "R2"); drain();
        wr(2, 16'h0883, "R3");

        // R4: toggle fields
        wr(1, 16'h7070, "R4");
        wr(1, 16'h1040, "R4");
        wr(1, 16'h0000, "R4");

        // R6: bulk OUT accepted, then R7 rejections
        wr(0, 16'h0000, "R6");
        rep(0, 2'b00, 0, 1, 0, "R6");
        rep(0, 2'b00, 0, 1, 0, "R7");
        rep(0, 2'b00, 1, 0, 0, "R7");
        rep(0, 2'b00, 1, 1, 1, "R7");
        rep(0, 2'b00, 1, 1, 0, "R6");

        // R5: clear-only done flags with invariant writes
        wr(0, 16'h8080, "R5");
        wr(0, 16'h0080, "R5");

        // R8: control endpoint SETUP
        wr(4, 16'h0200, "R8");
        rep(4, 2'b01, 0, 1, 0, "R8");
        rep(4, 2'b00, 1, 1, 0, "R6");
        rep(4, 2'b01, 0, 1, 1, "R8");
        rep(4, 2'b01, 1, 1, 0, "R8");

        // R9: isochronous endpoint
        wr(5, 16'h0400, "R9");
        rep(5, 2'b00, 1, 0, 0, "R9");
        rep(5, 2'b10, 1, 0, 0, "R9");
        rep(5, 2'b00, 0, 0, 1, "R9");
        rep(5, 2'b10, 0, 0, 1, "R9");

        // R10: bulk IN
        wr(6, 16'h0000, "R10");
        rep(6, 2'b10, 0, 0, 0, "R10");
        rep(6, 2'b10, 0, 1, 1, "R10");
        rep(6, 2'b10, 0, 1, 0, "R10");
        rep(6, 2'b10, 0, 1, 0, "R10");

        // R12: same-cycle collision, hardware set beats written zero
        wr(7, 16'h0000, "R12");
        op(1, 7, 16'h4000, 1, 7, 2'b00, 0, 1, 0, 0, "R12");
        op(1, 7, 16'h0040, 1, 7, 2'b10, 0, 1, 0, 0, "R12");

        // R11: bus reset with a colliding write and report
        wr(3, 16'h3B3D, "R11");
        op(1, 3, 16'h7F7F, 1, 0, 2'b00, 0, 1, 0, 1, "R11");
        rep(0, 2'b00, 0, 1, 0, "R11");

        drain();
        @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule